// File: doc/BRIEF.md
# Floating-Point Issue Interlock

This block decides each cycle whether the floating-point instruction at the head of decode may move into the first execute stage (E1) or must wait. The decoder gives it one instruction descriptor per cycle: a valid flag, a class code, two source register indices and a destination register index. The block answers with a combinational stall and an issue strobe. If stall is high, the decoder keeps the same descriptor on the inputs until the instruction issues.

Internally, three countdown trackers hold the timing state. The first records how long E1 stays held by the last arithmetic instruction. The second records how long the independent divide/square-root unit stays busy, together with the destination register that unit will write. The third records how many cycles remain until the latest outstanding arithmetic result is complete, which governs reads of the status register. The arithmetic datapath and the register contents are not modelled here.

Top module: `fpu_issue_ctl`

## Requirements
- R1: A synchronous active-high reset clears every tracker. An instruction presented in the first cycle after reset issues in that same cycle.
- R2: Class codes on `in_cls` are: 0 single-precision arithmetic, 1 double-precision arithmetic, 2 divide/square root, 3 FP load/store, 4 status-register read. Codes 5 to 7 are reserved and are never stalled. `issue` equals `in_valid` and not `stall`. While `in_valid` is low, both `stall` and `issue` are low.
- R3: A double-precision instruction issued in cycle t holds E1 for `DP_OCC` cycles (default 6). Any class 0, 1 or 2 instruction stalls until cycle t+`DP_OCC` and issues in that cycle.
- R4: A load/store is never held back by E1 occupancy. It issues in cycle t+1 right after a double-precision instruction issued in cycle t.
- R5: A divide/square root issued in cycle t uses E1 for `DIV_INIT` cycles (default 1). Classes 0, 1 and 2 cannot issue before cycle t+`DIV_INIT`.
- R6: Once the divide initialization is over, an instruction whose three register indices all differ from the divide destination issues without delay. Only the rules of R3, R5, R8 and R9 can still stall it.
- R7: An instruction of class 0, 1, 2 or 3 that names the pending divide destination as source A, source B or destination stalls until cycle t+`DIV_INIT`+`DIV_LAT` (default latency 10).
- R8: A second divide/square root stalls until the first has written back, which is cycle t+`DIV_INIT`+`DIV_LAT`.
- R9: A status-register read may issue no earlier than cycle t+L+1 for every earlier arithmetic instruction issued in cycle t. L is `SP_LAT` (default 3) for class 0, `DP_LAT` (default 8) for class 1, and `DIV_INIT`+`DIV_LAT` for class 2. Status reads ignore register indices and E1 occupancy.
- R10: Single-precision arithmetic holds E1 for one cycle only, so class-0 instructions can issue on consecutive cycles.
- R11: A stalled descriptor is held unchanged on the inputs and issues in the first cycle in which no rule stalls it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Descriptor present this cycle |
| in_cls | input | 3 | Instruction class code (see R2) |
| in_src_a | input | RIDX_W | First source register index |
| in_src_b | input | RIDX_W | Second source register index |
| in_dst | input | RIDX_W | Destination register index |
| issue | output | 1 | Instruction enters E1 this cycle |
| stall | output | 1 | Instruction must wait (combinational) |

## Verification
The bench targets the exact release cycle after each kind of occupancy. An off-by-one counter would release a waiting arithmetic instruction one cycle early or late after a double-precision instruction or a divide. A status read that only looked at the most recent instruction would issue too soon when a long divide was still outstanding behind a short single-precision op. Load/store issue right behind a double-precision op is checked, because a design that stalled every class on E1 occupancy would add needless bubbles. The bench also checks register matches on each of the three operand fields against the pending divide destination, since a missed field lets a dependent instruction read a stale result.

// File: rtl/fpu_il_pkg.sv
package fpu_il_pkg;
   typedef enum logic [2:0] {
      CLS_SP   = 3'd0,
      CLS_DP   = 3'd1,
      CLS_DIV  = 3'd2,
      CLS_LDST = 3'd3,
      CLS_STAT = 3'd4
   } fcls_e;
endpackage

// File: rtl/fpu_il_occ.sv
// Plain countdown: load sets the remaining-cycle count, busy while non-zero.
module fpu_il_occ #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          busy
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign busy = (cnt_q != '0);

   // R1
   occ_reset_chk: assert property (@(posedge clk) rst |=> !busy);
   // R3
   occ_drain_chk: assert property (@(posedge clk) disable iff (rst)
      (busy && !load) |=> (cnt_q < $past(cnt_q)));
endmodule

// File: rtl/fpu_il_cmpl.sv
// Completion tracker: keeps the later of the running and the newly loaded latency.
module fpu_il_cmpl #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          busy
);
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] dec;
   logic [CW-1:0] nxt;

   always_comb begin
      dec = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
      nxt = dec;
      if (load && (load_val > dec))
         nxt = load_val;
   end

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else
         cnt_q <= nxt;
   end

   assign busy = (cnt_q != '0);

   // R1
   cmpl_reset_chk: assert property (@(posedge clk) rst |=> !busy);
   // R9
   cmpl_keep_chk: assert property (@(posedge clk) disable iff (rst)
      load |=> (cnt_q >= $past(load_val)));
endmodule

// File: rtl/fpu_il_div.sv
// Divide/sqrt unit tracker: busy window plus the pending destination index.
module fpu_il_div #(
   parameter int CW     = 4,
   parameter int RIDX_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [CW-1:0]     start_len,
   input  logic [RIDX_W-1:0] start_dst,
   output logic              busy,
   output logic [RIDX_W-1:0] dst_q
);
   fpu_il_occ #(.CW(CW)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .load     (start),
      .load_val (start_len),
      .busy     (busy)
   );

   always_ff @(posedge clk) begin
      if (rst)
         dst_q <= '0;
      else if (start)
         dst_q <= start_dst;
   end

   // R7
   div_dst_chk: assert property (@(posedge clk) disable iff (rst)
      start |=> (busy && dst_q == $past(start_dst)));
endmodule

// File: rtl/fpu_issue_ctl.sv
module fpu_issue_ctl #(
   parameter int RIDX_W   = 4,
   parameter int DP_OCC   = 6,
   parameter int DP_LAT   = 8,
   parameter int SP_LAT   = 3,
   parameter int DIV_INIT = 1,
   parameter int DIV_LAT  = 10
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [2:0]        in_cls,
   input  logic [RIDX_W-1:0] in_src_a,
   input  logic [RIDX_W-1:0] in_src_b,
   input  logic [RIDX_W-1:0] in_dst,
   output logic              issue,
   output logic              stall
);
   import fpu_il_pkg::*;

   localparam int DIV_TOT = DIV_INIT + DIV_LAT;
   localparam int MAX_AB  = (DP_LAT > SP_LAT) ? DP_LAT : SP_LAT;
   localparam int MAX_L   = (MAX_AB > DIV_TOT) ? MAX_AB : DIV_TOT;
   localparam int CW      = $clog2(MAX_L + 1);
   localparam int N_OPND  = 3;

   if (DP_OCC < 1) begin : g_bad_occ
      $error("DP_OCC must be at least 1");
   end
   if (DIV_INIT < 1) begin : g_bad_init
      $error("DIV_INIT must be at least 1");
   end
   if (DP_LAT < DP_OCC) begin : g_bad_dplat
      $error("DP_LAT must not be below DP_OCC");
   end
   if ((SP_LAT < 1) || (DIV_LAT < 1)) begin : g_bad_lat
      $error("latencies must be at least 1");
   end
   if (RIDX_W < 1) begin : g_bad_ridx
      $error("RIDX_W must be at least 1");
   end

   fcls_e cls;
   logic  is_sp, is_dp, is_div, is_stat, uses_e1;
   assign cls     = fcls_e'(in_cls);
   assign is_sp   = (cls == CLS_SP);
   assign is_dp   = (cls == CLS_DP);
   assign is_div  = (cls == CLS_DIV);
   assign is_stat = (cls == CLS_STAT);
   assign uses_e1 = is_sp | is_dp | is_div;

   logic              e1_busy, div_busy, cmpl_busy;
   logic [RIDX_W-1:0] div_dst;
   logic [CW-1:0]     e1_len, cmpl_len;

   always_comb begin
      if (is_dp)       e1_len = CW'(DP_OCC - 1);
      else if (is_div) e1_len = CW'(DIV_INIT - 1);
      else             e1_len = '0;
      if (is_dp)       cmpl_len = CW'(DP_LAT);
      else if (is_div) cmpl_len = CW'(DIV_TOT);
      else             cmpl_len = CW'(SP_LAT);
   end

   fpu_il_occ #(.CW(CW)) u_e1 (
      .clk      (clk),
      .rst      (rst),
      .load     (issue & uses_e1),
      .load_val (e1_len),
      .busy     (e1_busy)
   );

   fpu_il_div #(.CW(CW), .RIDX_W(RIDX_W)) u_div (
      .clk       (clk),
      .rst       (rst),
      .start     (issue & is_div),
      .start_len (CW'(DIV_TOT - 1)),
      .start_dst (in_dst),
      .busy      (div_busy),
      .dst_q     (div_dst)
   );

   fpu_il_cmpl #(.CW(CW)) u_cmpl (
      .clk      (clk),
      .rst      (rst),
      .load     (issue & uses_e1),
      .load_val (cmpl_len),
      .busy     (cmpl_busy)
   );

   // register match of every operand field against the pending divide result
   logic [RIDX_W-1:0] opnd [N_OPND];
   logic [N_OPND-1:0] opnd_hit;
   assign opnd[0] = in_src_a;
   assign opnd[1] = in_src_b;
   assign opnd[2] = in_dst;
   for (genvar k = 0; k < N_OPND; k++) begin : g_match
      assign opnd_hit[k] = (opnd[k] == div_dst);
   end

   logic e1_hold, unit_hold, reg_hold, stat_hold;
   assign e1_hold   = uses_e1 & e1_busy;
   assign unit_hold = is_div & div_busy;
   assign reg_hold  = (uses_e1 | (cls == CLS_LDST)) & div_busy & (|opnd_hit);
   assign stat_hold = is_stat & cmpl_busy;

   assign stall = in_valid & (e1_hold | unit_hold | reg_hold | stat_hold);
   assign issue = in_valid & ~stall;

   // R3
   if (DP_OCC > 1) begin : g_dp_chk
      dp_hold_chk: assert property (@(posedge clk) disable iff (rst)
         (issue && is_dp) |=> (!in_valid || !uses_e1 || stall));
   end
   // R8
   div_excl_chk: assert property (@(posedge clk) disable iff (rst)
      (issue && is_div) |=> !(issue && is_div));
   // R9
   stat_after_chk: assert property (@(posedge clk) disable iff (rst)
      (issue && uses_e1) |=> !(issue && is_stat));
   // R11
   hold_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && stall) |=> (in_valid && $stable(in_cls) && $stable(in_dst)
                               && $stable(in_src_a) && $stable(in_src_b)));
endmodule

// File: tb/fpu_issue_ctl_bench.sv
module fpu_issue_ctl_bench;
   localparam int RW = 4, DPO = 6, DPL = 8, SPL = 3, DVI = 1, DVL = 10;

   logic clk = 1'b0, rst = 1'b1;
   logic in_valid = 1'b0;
   logic [2:0] in_cls = '0;
   logic [RW-1:0] in_src_a = '0, in_src_b = '0, in_dst = '0;
   logic issue, stall;

   always #10 clk = ~clk;

   fpu_issue_ctl #(.RIDX_W(RW), .DP_OCC(DPO), .DP_LAT(DPL), .SP_LAT(SPL),
                   .DIV_INIT(DVI), .DIV_LAT(DVL)) u_fpu_issue_ctl (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_cls(in_cls),
      .in_src_a(in_src_a), .in_src_b(in_src_b), .in_dst(in_dst),
      .issue(issue), .stall(stall));

   int checks = 0, errors = 0, cyc = 0;
   int e1_free = 0, div_done = 0, stat_ok = 0;
   logic [RW-1:0] dv_dst = '0;
   bit last_iss;
   int last_at;

   task automatic chk(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   function automatic string tag_of();
      if (!in_valid) return "R2";
      case (in_cls)
         3'd0: return "R10";
         3'd1: return "R3";
         3'd2: return "R8";
         3'd3: return "R4";
         default: return "R9";
      endcase
   endfunction

   function automatic bit exp_stall();
      bit arith, hit;
      if (!in_valid) return 1'b0;
      arith = (in_cls <= 3'd2);
      hit = (in_src_a == dv_dst) || (in_src_b == dv_dst) || (in_dst == dv_dst);
      if (arith && cyc < e1_free) return 1'b1;
      if (in_cls == 3'd2 && cyc < div_done) return 1'b1;
      if (in_cls <= 3'd3 && cyc < div_done && hit) return 1'b1;
      if (in_cls == 3'd4 && cyc < stat_ok) return 1'b1;
      return 1'b0;
   endfunction

   task automatic tick();
      bit es, ei;
      @(negedge clk);
      es = exp_stall();
      ei = in_valid && !es;
      chk(stall == es, tag_of(), int'(stall), int'(es));
      chk(issue == ei, "R2", int'(issue), int'(ei));
      last_iss = ei;
      last_at = cyc;
      if (ei) begin
         case (in_cls)
            3'd0: begin e1_free = cyc + 1;
                  if (cyc + SPL + 1 > stat_ok) stat_ok = cyc + SPL + 1; end
            3'd1: begin e1_free = cyc + DPO;
                  if (cyc + DPL + 1 > stat_ok) stat_ok = cyc + DPL + 1; end
            3'd2: begin e1_free = cyc + DVI; div_done = cyc + DVI + DVL;
                  dv_dst = in_dst;
                  if (cyc + DVI + DVL + 1 > stat_ok) stat_ok = cyc + DVI + DVL + 1; end
            default: ;
         endcase
      end
      @(posedge clk);
      #1 cyc++;
   endtask

   task automatic send(int c, int a, int b, int d, output int at);
      in_valid = 1'b1; in_cls = 3'(c);
      in_src_a = RW'(a); in_src_b = RW'(b); in_dst = RW'(d);
      at = -1;
      for (int g = 0; g < 100; g++) begin
         tick();
         if (last_iss) begin at = last_at; break; end
      end
      in_valid = 1'b0;
   endtask

   int t0, t1, t2;

   initial begin
      void'($urandom(32'd4177));
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      // R1 R2: idle after reset, then immediate issue
      @(negedge clk);
      chk(stall == 1'b0 && issue == 1'b0, "R1", int'(stall | issue), 0);
      send(0, 1, 2, 3, t0);
      chk(t0 == 0, "R1", t0, 0);
      // R10: consecutive single-precision
      send(0, 1, 2, 4, t0); send(0, 2, 3, 4, t1);
      chk(t1 - t0 == 1, "R10", t1 - t0, 1);
      // R3: double then single waits DP_OCC
      send(1, 1, 2, 3, t0); send(0, 4, 5, 6, t1);
      chk(t1 - t0 == DPO, "R3", t1 - t0, DPO);
      // R4: double then load/store no wait
      send(1, 1, 2, 3, t0); send(3, 4, 5, 6, t1);
      chk(t1 - t0 == 1, "R4", t1 - t0, 1);
      repeat (12) tick();
      // R5 R6 R7: divide, independent op, dependent op
      send(2, 1, 2, 9, t0); send(0, 3, 4, 5, t1);
      chk(t1 - t0 == DVI, "R5", t1 - t0, DVI);
      chk(t1 - t0 == DVI, "R6", t1 - t0, DVI);
      send(3, 0, 9, 7, t2);
      chk(t2 - t0 == DVI + DVL, "R7", t2 - t0, DVI + DVL);
      send(2, 1, 2, 11, t0); send(0, 3, 4, 11, t2);
      chk(t2 - t0 == DVI + DVL, "R7", t2 - t0, DVI + DVL);
      // R8: divide after divide
      send(2, 1, 2, 3, t0); send(2, 4, 5, 6, t1);
      chk(t1 - t0 == DVI + DVL, "R8", t1 - t0, DVI + DVL);
      repeat (14) tick();
      // R9: status read after single, and after divide behind a single
      send(0, 1, 2, 3, t0); send(4, 0, 0, 0, t1);
      chk(t1 - t0 == SPL + 1, "R9", t1 - t0, SPL + 1);
      send(2, 1, 2, 3, t0); send(0, 4, 5, 6, t2); send(4, 0, 0, 0, t1);
      chk(t1 - t0 == DVI + DVL + 1, "R9", t1 - t0, DVI + DVL + 1);
      // R11 and all rules: random stream with held descriptors
      for (int i = 0; i < 1500; i++) begin
         if ($urandom_range(4) == 0) begin
            in_cls = 3'($urandom_range(7));
            tick();
         end else begin
            send($urandom_range(4), $urandom_range(7), $urandom_range(7),
                 $urandom_range(7), t0);
            chk(t0 >= 0, "R11", t0, 0);
         end
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule